// File: doc/BRIEF.md
# Legacy Eight-Channel DMA Register Bank

This block is the register file of a two-tier, eight-channel DMA controller of the old PC kind. It serves only the programming side. A host reaches it through a byte-wide I/O port bus with write and read strobes. The block keeps the setup for each channel: start address, transfer length, mode and mask. It presents that setup on per-channel outputs for a transfer engine elsewhere in the chip. Bus mastering, request/acknowledge handshaking, arbitration and interrupts are not part of this block.

Channels 0 to 3 form a byte group. Channels 4 to 7 form a word group, whose address and count are counted in 16-bit words. Channel 4 links the two groups, so it has no page registers. Each group has one byte pointer. This pointer lets two consecutive one-byte accesses reach the low and then the high half of a 16-bit register.

The port bus has no back-pressure. Every strobe is taken in the cycle it is high. Read data is driven combinationally during a read strobe. Register state, including the byte pointer, changes at the clock edge that ends the strobe cycle.

Top module: `dma_regbank`

## Requirements
- R1: After reset, every channel is masked (`ch_enable` all 0). Both byte pointers select the low byte. Address, count, mode and page registers read as zero, so `ch_base_addr`, `ch_base_cnt` and `ch_mode` are all zero.
- R2: In the byte group, channel n has its address at port 2n and its count at port 2n+1 (n = 0..3). Any write or read of one of these eight ports reaches the byte chosen by the group pointer: low when the pointer is 0, high when it is 1. The access then flips the pointer. One pointer serves both address and count ports.
- R3: A write of any value to port 0x0C (byte group) or 0xD8 (word group) sets that group's pointer back to the low byte.
- R4: In the word group, channel 4+n has its address at port 0xC0+4n and its count at port 0xC2+4n. Odd ports inside 0xC0–0xCF are not decoded: writes to them change nothing, and they do not move the pointer.
- R5: A write to port 0x0A (byte group) or 0xD4 (word group) selects a channel of that group with data bits 1:0. Data bit 2 = 1 masks that channel and bit 2 = 0 unmasks it. `ch_enable[i]` is high while channel i is unmasked.
- R6: A write to port 0x0B (byte group) or 0xD6 (word group) selects a channel with bits 1:0 and stores data bits 7:2 as that channel's 6-bit mode on `ch_mode`.
- R7: The low page ports are 0x087, 0x083, 0x081, 0x082, 0x08B, 0x089 and 0x08A, for channels 0,1,2,3,5,6,7. The high page ports are the same addresses plus 0x400. All are readable and writable. For channels 0–3, `ch_base_addr` = {high page, low page, address}.
- R8: For channels 5–7, `ch_base_addr` = {high page, low page bits 7:1, word address, 1'b0}.
- R9: Channel 4 has no page registers. Its `ch_base_addr` is {15'b0, word address, 1'b0}, and ports 0x084/0x484 are not decoded.
- R10: A write to port 0x0D (byte group) or 0xDA (word group) returns only that group to the R1 state: masks, pointer, addresses, counts and modes. Page registers and the other group keep their contents.
- R11: The two groups' byte pointers are independent. An access in one group neither reads nor moves the other group's pointer.
- R12: `ch_base_cnt` shows each channel's count register (transfer length minus one). A count port reads back that register byte by byte. A read of any port that is not an address, count or page port returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Port write strobe, one cycle per access |
| bus_rd | input | 1 | Port read strobe, one cycle per access |
| bus_port | input | PORT_W | I/O port address |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte, valid while bus_rd is high |
| ch_base_addr | output | 8*32 | Per-channel byte start address, channel i at bits 32i+31:32i |
| ch_base_cnt | output | 8*16 | Per-channel count register, channel i at bits 16i+15:16i |
| ch_mode | output | 8*6 | Per-channel mode, channel i at bits 6i+5:6i |
| ch_enable | output | 8 | Per-channel unmasked flag |

## Verification
The assertions assume that a write strobe and a read strobe are never high in the same cycle. They also assume that bus_port and bus_wdata are stable while a strobe is high. A separate property flags any overlap of the two strobes. The bench drives every access through one task, which raises exactly one strobe for exactly one cycle. So the pointer toggle, clear and mask/mode checks always see one well-formed access at a time.

// File: rtl/dma_rb_pkg.sv
package dma_rb_pkg;

  localparam int NCH      = 8;
  localparam int GRP_CH   = 4;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 16;
  localparam int MODE_W   = 6;
  localparam int BADDR_W  = 32;

  // Map the low nibble of a page port to {valid, channel}.
  function automatic logic [3:0] page_slot(input logic [3:0] nib);
    case (nib)
      4'h7:    page_slot = {1'b1, 3'd0};
      4'h3:    page_slot = {1'b1, 3'd1};
      4'h1:    page_slot = {1'b1, 3'd2};
      4'h2:    page_slot = {1'b1, 3'd3};
      4'hB:    page_slot = {1'b1, 3'd5};
      4'h9:    page_slot = {1'b1, 3'd6};
      4'hA:    page_slot = {1'b1, 3'd7};
      default: page_slot = 4'h0;
    endcase
  endfunction

endpackage

// File: rtl/dma_grp_regs.sv
module dma_grp_regs #(
  parameter int          PORT_W     = 12,
  parameter int unsigned BASE_PORT  = 0,
  parameter int          CH_SHIFT   = 1,
  parameter int          SEL_SHIFT  = 0,
  parameter int unsigned MASK_PORT  = 'h0A,
  parameter int unsigned MODE_PORT  = 'h0B,
  parameter int unsigned CLR_PORT   = 'h0C,
  parameter int unsigned MCLR_PORT  = 'h0D
) (
  input  logic                                             clk,
  input  logic                                             rst_n,
  input  logic                                             wr,
  input  logic                                             rd,
  input  logic [PORT_W-1:0]                                port,
  input  logic [dma_rb_pkg::BYTE_W-1:0]                    wdata,
  output logic [dma_rb_pkg::BYTE_W-1:0]                    rdata,
  output logic [dma_rb_pkg::GRP_CH-1:0][dma_rb_pkg::WORD_W-1:0] addr_q,
  output logic [dma_rb_pkg::GRP_CH-1:0][dma_rb_pkg::WORD_W-1:0] cnt_q,
  output logic [dma_rb_pkg::GRP_CH-1:0][dma_rb_pkg::MODE_W-1:0] mode_q,
  output logic [dma_rb_pkg::GRP_CH-1:0]                    mask_q
);
  import dma_rb_pkg::*;

  localparam logic [PORT_W-1:0] BASE     = PORT_W'(BASE_PORT);
  localparam logic [PORT_W-1:0] WIN      = PORT_W'(GRP_CH << CH_SHIFT);
  localparam logic [PORT_W-1:0] LOW_MASK = PORT_W'((1 << SEL_SHIFT) - 1);
  localparam logic [PORT_W-1:0] P_MASK   = PORT_W'(MASK_PORT);
  localparam logic [PORT_W-1:0] P_MODE   = PORT_W'(MODE_PORT);
  localparam logic [PORT_W-1:0] P_CLR    = PORT_W'(CLR_PORT);
  localparam logic [PORT_W-1:0] P_MCLR   = PORT_W'(MCLR_PORT);

  logic [PORT_W-1:0] off;
  logic              in_win, is_cnt, acc;
  logic              mask_wr, mode_wr, clr_wr, mclr_wr;
  logic [1:0]        ch_sel;
  logic              ptr_q;
  logic [WORD_W-1:0] sel_word;

  assign off     = port - BASE;
  assign in_win  = (off < WIN) && ((off & LOW_MASK) == '0);
  assign ch_sel  = off[CH_SHIFT +: 2];
  assign is_cnt  = off[SEL_SHIFT];
  assign acc     = in_win && (wr || rd);
  assign mask_wr = wr && (port == P_MASK);
  assign mode_wr = wr && (port == P_MODE);
  assign clr_wr  = wr && (port == P_CLR);
  assign mclr_wr = wr && (port == P_MCLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
      mode_q <= '0;
      mask_q <= '1;
    end else if (mclr_wr) begin
      ptr_q  <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
      mode_q <= '0;
      mask_q <= '1;
    end else begin
      if (clr_wr)      ptr_q <= 1'b0;
      else if (acc)    ptr_q <= ~ptr_q;
      if (wr && in_win) begin
        if (is_cnt) begin
          if (ptr_q) cnt_q[ch_sel][15:8]  <= wdata;
          else       cnt_q[ch_sel][7:0]   <= wdata;
        end else begin
          if (ptr_q) addr_q[ch_sel][15:8] <= wdata;
          else       addr_q[ch_sel][7:0]  <= wdata;
        end
      end
      if (mask_wr) mask_q[wdata[1:0]] <= wdata[2];
      if (mode_wr) mode_q[wdata[1:0]] <= wdata[7:2];
    end
  end

  always_comb begin
    sel_word = is_cnt ? cnt_q[ch_sel] : addr_q[ch_sel];
    rdata    = '0;
    if (rd && in_win) rdata = ptr_q ? sel_word[15:8] : sel_word[7:0];
  end

  // R2: every address/count access flips the byte pointer
  p_ptr_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (ptr_q != $past(ptr_q)));

  // R2: strobes never overlap (input assumption)
  p_no_wr_rd_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && rd));

  // R3: pointer clear
  p_clr_ptr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> !ptr_q);

  // R5: single-channel mask
  p_mask_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_q[$past(wdata[1:0])] == $past(wdata[2])));

  // R6: mode store
  p_mode_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (mode_q[$past(wdata[1:0])] == $past(wdata[7:2])));

  // R10: group master clear
  p_group_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mclr_wr |=> (mask_q == '1 && !ptr_q && addr_q == '0 && cnt_q == '0 && mode_q == '0));

endmodule

// File: rtl/dma_page_bank.sv
module dma_page_bank #(
  parameter int          PORT_W  = 12,
  parameter int unsigned LO_BASE = 'h080,
  parameter int unsigned HI_BASE = 'h480
) (
  input  logic                                              clk,
  input  logic                                              rst_n,
  input  logic                                              wr,
  input  logic                                              rd,
  input  logic [PORT_W-1:0]                                 port,
  input  logic [dma_rb_pkg::BYTE_W-1:0]                     wdata,
  output logic [dma_rb_pkg::BYTE_W-1:0]                     rdata,
  output logic [dma_rb_pkg::NCH-1:0][dma_rb_pkg::BYTE_W-1:0] pg_lo,
  output logic [dma_rb_pkg::NCH-1:0][dma_rb_pkg::BYTE_W-1:0] pg_hi
);
  import dma_rb_pkg::*;

  localparam logic [PORT_W-1:0] LO = PORT_W'(LO_BASE);
  localparam logic [PORT_W-1:0] HI = PORT_W'(HI_BASE);

  logic [3:0] slot;
  logic [2:0] ch;
  logic       lo_hit, hi_hit;

  assign slot   = page_slot(port[3:0]);
  assign ch     = slot[2:0];
  assign lo_hit = slot[3] && (port[PORT_W-1:4] == LO[PORT_W-1:4]);
  assign hi_hit = slot[3] && (port[PORT_W-1:4] == HI[PORT_W-1:4]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_lo <= '0;
      pg_hi <= '0;
    end else if (wr) begin
      if (lo_hit) pg_lo[ch] <= wdata;
      if (hi_hit) pg_hi[ch] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd && lo_hit)      rdata = pg_lo[ch];
    else if (rd && hi_hit) rdata = pg_hi[ch];
  end

  // R7: page write lands in the decoded channel
  p_page_lo_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && lo_hit) |=> (pg_lo[$past(ch)] == $past(wdata)));

  p_page_hi_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hi_hit) |=> (pg_hi[$past(ch)] == $past(wdata)));

endmodule

// File: rtl/dma_regbank.sv
module dma_regbank #(
  parameter int PORT_W = 12
) (
  input  logic                                               clk,
  input  logic                                               rst_n,
  input  logic                                               bus_wr,
  input  logic                                               bus_rd,
  input  logic [PORT_W-1:0]                                  bus_port,
  input  logic [7:0]                                         bus_wdata,
  output logic [7:0]                                         bus_rdata,
  output logic [dma_rb_pkg::NCH*dma_rb_pkg::BADDR_W-1:0]     ch_base_addr,
  output logic [dma_rb_pkg::NCH*dma_rb_pkg::WORD_W-1:0]      ch_base_cnt,
  output logic [dma_rb_pkg::NCH*dma_rb_pkg::MODE_W-1:0]      ch_mode,
  output logic [dma_rb_pkg::NCH-1:0]                         ch_enable
);
  import dma_rb_pkg::*;

  logic [BYTE_W-1:0] a_rd, b_rd, p_rd;
  logic [GRP_CH-1:0][WORD_W-1:0] a_addr, a_cnt, b_addr, b_cnt;
  logic [GRP_CH-1:0][MODE_W-1:0] a_mode, b_mode;
  logic [GRP_CH-1:0]             a_mask, b_mask;
  logic [NCH-1:0][BYTE_W-1:0]    pg_lo, pg_hi;
  logic                          unused_pg_bits;

  dma_grp_regs #(
    .PORT_W(PORT_W), .BASE_PORT('h000), .CH_SHIFT(1), .SEL_SHIFT(0),
    .MASK_PORT('h0A), .MODE_PORT('h0B), .CLR_PORT('h0C), .MCLR_PORT('h0D)
  ) u_byte_grp (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .port(bus_port),
    .wdata(bus_wdata), .rdata(a_rd), .addr_q(a_addr), .cnt_q(a_cnt),
    .mode_q(a_mode), .mask_q(a_mask)
  );

  dma_grp_regs #(
    .PORT_W(PORT_W), .BASE_PORT('h0C0), .CH_SHIFT(2), .SEL_SHIFT(1),
    .MASK_PORT('hD4), .MODE_PORT('hD6), .CLR_PORT('hD8), .MCLR_PORT('hDA)
  ) u_word_grp (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .port(bus_port),
    .wdata(bus_wdata), .rdata(b_rd), .addr_q(b_addr), .cnt_q(b_cnt),
    .mode_q(b_mode), .mask_q(b_mask)
  );

  dma_page_bank #(
    .PORT_W(PORT_W), .LO_BASE('h080), .HI_BASE('h480)
  ) u_pages (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .port(bus_port),
    .wdata(bus_wdata), .rdata(p_rd), .pg_lo(pg_lo), .pg_hi(pg_hi)
  );

  assign bus_rdata = a_rd | b_rd | p_rd;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int C = i % GRP_CH;
    if (i < GRP_CH) begin : g_byte
      assign ch_base_addr[i*BADDR_W +: BADDR_W] = {pg_hi[i], pg_lo[i], a_addr[C]};
      assign ch_base_cnt[i*WORD_W +: WORD_W]    = a_cnt[C];
      assign ch_mode[i*MODE_W +: MODE_W]        = a_mode[C];
      assign ch_enable[i]                       = ~a_mask[C];
    end else begin : g_word
      if (C == 0) begin : g_link
        assign ch_base_addr[i*BADDR_W +: BADDR_W] =
          {{(BADDR_W-WORD_W-1){1'b0}}, b_addr[C], 1'b0};
      end else begin : g_paged
        assign ch_base_addr[i*BADDR_W +: BADDR_W] =
          {pg_hi[i], pg_lo[i][BYTE_W-1:1], b_addr[C], 1'b0};
      end
      assign ch_base_cnt[i*WORD_W +: WORD_W] = b_cnt[C];
      assign ch_mode[i*MODE_W +: MODE_W]     = b_mode[C];
      assign ch_enable[i]                    = ~b_mask[C];
    end
  end

  assign unused_pg_bits = ^{pg_lo[4], pg_hi[4], pg_lo[5][0], pg_lo[6][0], pg_lo[7][0]};

  // R12: only one source drives read data at a time
  p_single_reader_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({a_rd != '0, b_rd != '0, p_rd != '0}) <= 1);

endmodule

// File: tb/sim_dma_regbank.sv
module sim_dma_regbank;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0;
  logic         bus_rd = 1'b0;
  logic [11:0]  bus_port = '0;
  logic [7:0]   bus_wdata = '0;
  logic [7:0]   bus_rdata;
  logic [255:0] ch_base_addr;
  logic [127:0] ch_base_cnt;
  logic [47:0]  ch_mode;
  logic [7:0]   ch_enable;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_regbank u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_port(bus_port), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ch_base_addr(ch_base_addr), .ch_base_cnt(ch_base_cnt),
    .ch_mode(ch_mode), .ch_enable(ch_enable)
  );

  task automatic wr(input logic [11:0] p, input logic [7:0] d);
    @(posedge clk); #1;
    bus_port = p; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] p, input logic [7:0] e, input string tag);
    @(posedge clk); #1;
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_port = p; bus_rd = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  // Monitor: pops the scoreboard while a read strobe is active.
  always @(negedge clk) begin
    if (bus_rd && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s port=%h actual=%h expected=%h", t, bus_port, bus_rdata, e);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] e);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, e);
    end
  endtask

  function automatic logic [31:0] baddr(input int i);
    return ch_base_addr[i*32 +: 32];
  endfunction
  function automatic logic [15:0] bcnt(input int i);
    return ch_base_cnt[i*16 +: 16];
  endfunction
  function automatic logic [5:0] bmode(input int i);
    return ch_mode[i*6 +: 6];
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk("R1 enable", {24'h0, ch_enable}, 32'h0);
    for (int i = 0; i < 8; i++) chk("R1 base addr", baddr(i), 32'h0);
    chk("R1 mode ch5", {26'h0, bmode(5)}, 32'h0);
    rd(12'h000, 8'h00, "R1 addr lo");
    rd(12'h000, 8'h00, "R1 addr hi");
    rd(12'h087, 8'h00, "R1 page");

    // R2 two-byte access, R12 count readback
    wr(12'h002, 8'h34); wr(12'h002, 8'h12);
    wr(12'h003, 8'hFF); wr(12'h003, 8'h00);
    chk("R2 ch1 addr", baddr(1), 32'h0000_1234);
    chk("R12 ch1 count", {16'h0, bcnt(1)}, 32'h0000_00FF);
    rd(12'h002, 8'h34, "R2 read lo");
    rd(12'h002, 8'h12, "R2 read hi");
    rd(12'h003, 8'hFF, "R12 count lo");
    rd(12'h003, 8'h00, "R12 count hi");
    rd(12'h00E, 8'h00, "R12 undecoded port");
    rd(12'h00A, 8'h00, "R12 mask port read");

    // R3 pointer clear mid-pair
    wr(12'h000, 8'hAA); wr(12'h00C, 8'h00);
    wr(12'h000, 8'h55); wr(12'h000, 8'h66);
    chk("R3 ch0 addr", baddr(0), 32'h0000_6655);
    rd(12'h000, 8'h55, "R3 read lo");
    rd(12'h000, 8'h66, "R3 read hi");

    // R2 shared pointer across address/count, reads also toggle
    wr(12'h00C, 8'h00);
    wr(12'h004, 8'h11); wr(12'h005, 8'h22);
    chk("R2 shared ptr addr", baddr(2), 32'h0000_0011);
    chk("R2 shared ptr count", {16'h0, bcnt(2)}, 32'h0000_2200);
    wr(12'h00C, 8'h00);
    rd(12'h004, 8'h11, "R2 read toggles");
    wr(12'h004, 8'h77);
    chk("R2 write after read", baddr(2), 32'h0000_7711);

    // R11 independent pointers
    wr(12'h006, 8'h01);
    wr(12'h0C4, 8'h01); wr(12'h0C4, 8'h80);
    wr(12'h006, 8'h02);
    chk("R11 byte group ptr kept", baddr(3), 32'h0000_0201);

    // R4 word group ports, odd port ignored
    wr(12'h0C6, 8'h34); wr(12'h0C6, 8'h12);
    chk("R4 ch5 count", {16'h0, bcnt(5)}, 32'h0000_1234);
    wr(12'h0C5, 8'hEE);
    rd(12'h0C4, 8'h01, "R4 odd port no toggle lo");
    rd(12'h0C4, 8'h80, "R4 odd port no toggle hi");
    chk("R4 count after odd write", {16'h0, bcnt(5)}, 32'h0000_1234);

    // R8 word channel address
    wr(12'h08B, 8'h13); wr(12'h48B, 8'h7F);
    chk("R8 ch5 base", baddr(5), 32'h7F13_0002);
    rd(12'h08B, 8'h13, "R7 page lo read");
    rd(12'h48B, 8'h7F, "R7 page hi read");

    // R7 byte channel pages
    wr(12'h083, 8'hAB); wr(12'h483, 8'hCD);
    chk("R7 ch1 base", baddr(1), 32'hCDAB_1234);
    wr(12'h087, 8'h01);
    chk("R7 ch0 base", baddr(0), 32'h0001_6655);
    wr(12'h08A, 8'h02);
    chk("R8 ch7 base", baddr(7), 32'h0002_0000);

    // R9 link channel
    wr(12'h0C0, 8'hFF); wr(12'h0C0, 8'hFF);
    chk("R9 ch4 base", baddr(4), 32'h0001_FFFE);
    wr(12'h084, 8'h55); wr(12'h484, 8'h55);
    rd(12'h084, 8'h00, "R9 no page port");
    chk("R9 ch4 base kept", baddr(4), 32'h0001_FFFE);

    // R5 mask
    wr(12'h00A, 8'h01);
    chk("R5 unmask ch1", {24'h0, ch_enable}, 32'h02);
    wr(12'h00A, 8'h03);
    chk("R5 unmask ch3", {24'h0, ch_enable}, 32'h0A);
    wr(12'h00A, 8'h05);
    chk("R5 mask ch1", {24'h0, ch_enable}, 32'h08);
    wr(12'h0D4, 8'h02); wr(12'h0D4, 8'h00);
    chk("R5 word group unmask", {24'h0, ch_enable}, 32'h58);

    // R6 mode
    wr(12'h00B, 8'h4A);
    chk("R6 ch2 mode", {26'h0, bmode(2)}, 32'h12);
    wr(12'h0D6, 8'hC1);
    chk("R6 ch5 mode", {26'h0, bmode(5)}, 32'h30);
    chk("R6 ch1 mode untouched", {26'h0, bmode(1)}, 32'h0);

    // R10 word group master clear
    wr(12'h0C8, 8'h44);
    wr(12'h0DA, 8'h00);
    chk("R10 enables", {24'h0, ch_enable}, 32'h08);
    chk("R10 ch5 base keeps page", baddr(5), 32'h7F12_0000);
    chk("R10 ch5 count", {16'h0, bcnt(5)}, 32'h0);
    chk("R10 ch5 mode", {26'h0, bmode(5)}, 32'h0);
    chk("R10 other group kept", baddr(1), 32'hCDAB_1234);
    wr(12'h0C8, 8'h99);
    chk("R10 pointer low", baddr(6), 32'h0000_0132);

    wait (exp_q.size() == 0);
    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule